// File: doc/BRIEF.md
# Page Sharing Classifier

This block keeps a per-page record of which core a data page belongs to and whether it has become shared. It is consulted when a core misses in its TLB. The request names a page and the requesting core. The block answers with one bit that the TLB fill carries: private or shared. Each page number in the tracked range has its own table slot, so the table is indexed directly by page number. A slot holds a 2-bit class and the owner core number.

The first core to miss on an unclassified page becomes its owner, and the page is private to that core. A miss from any other core on a private page promotes the page to shared for good. Before the requester gets its answer, the block performs two actions on the old owner. It asks the owner to drop its TLB translation for the page, and it asks the owner's cache slice to evict that page's blocks. Both requests must be acknowledged before the reply is released.

Misses are served one at a time. Each stream uses valid/ready. A source holds valid and its payload steady until ready is seen at a clock edge, and the block does the same on its outputs. `miss_ready` is high only while the block is idle, so a new miss stalls until the previous reply has been taken.

Top module: `page_class_unit`

## Requirements
- R1: Reset clears every slot to unclassified (class code 2'b00; the other codes are 2'b01 private, 2'b10 shared, 2'b11 instruction). After reset, `miss_ready` is high and no valid output is asserted.
- R2: A miss on an unclassified page is answered with `rsp_shared`=0. The page becomes private to the requesting core, and no invalidate or evict request is issued.
- R3: A miss by the owner on its own private page is answered with `rsp_shared`=0 and causes no invalidate or evict request.
- R4: A miss by a core other than the owner on a private page causes exactly one invalidate request and exactly one evict request. Both carry the old owner's core number and the page number. The reply is `rsp_shared`=1.
- R5: In the case of R4, `rsp_valid` does not rise until both the invalidate handshake and the evict handshake have completed, whatever their order and delay.
- R6: A miss on a shared page from any core is answered with `rsp_shared`=1, with no invalidate or evict request, and the page stays shared.
- R7: `miss_ready` is low from the cycle after a miss is accepted until the cycle after its reply is accepted, so only one miss is in service at a time.
- R8: Once raised, `rsp_valid`, `rsp_shared`, `rsp_page` and `rsp_core` hold until `rsp_ready` is seen. The reply names the requester's core and page.
- R9: Once raised, each invalidate or evict valid holds, with a stable payload, until its ready is seen.
- R10: Slots are independent: promoting one page leaves the class and owner of every other page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | TLB miss request valid |
| miss_ready | output | 1 | Block can accept a miss |
| miss_page | input | 6 | Page number of the miss |
| miss_core | input | 4 | Requesting core |
| rsp_valid | output | 1 | Reply valid |
| rsp_ready | input | 1 | Reply accepted |
| rsp_shared | output | 1 | 1 = shared, 0 = private |
| rsp_page | output | 6 | Page number of the reply |
| rsp_core | output | 4 | Core the reply goes to |
| inv_valid | output | 1 | TLB invalidate request valid |
| inv_ready | input | 1 | Invalidate acknowledged |
| inv_page | output | 6 | Page to invalidate |
| inv_core | output | 4 | Core whose TLB is invalidated |
| evc_valid | output | 1 | Slice evict request valid |
| evc_ready | input | 1 | Evict acknowledged |
| evc_page | output | 6 | Page whose blocks are evicted |
| evc_core | output | 4 | Core whose slice evicts |

## Verification
The assertions assume that a miss source holds its page and core steady while `miss_valid` waits for `miss_ready`. They also assume that every invalidate, evict and reply is eventually acknowledged. The stimulus raises `miss_valid` only when `miss_ready` is already high, for one accepted cycle at a time. It answers each invalidate, evict and reply after a chosen delay of zero to three cycles, and it never drops a ready before the matching valid has been seen. Random misses are packed onto a handful of pages and cores, which makes owner repeats, promotions and shared hits frequent.

// File: rtl/page_class_pkg.sv
package page_class_pkg;
  typedef enum logic [1:0] {
    CLS_NONE   = 2'b00,
    CLS_PRIV   = 2'b01,
    CLS_SHARED = 2'b10,
    CLS_INSTR  = 2'b11
  } page_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHOOT = 2'b01,
    ST_REPLY = 2'b10
  } ctrl_state_e;
endpackage

// File: rtl/page_class_table.sv
module page_class_table
  import page_class_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CORE_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output page_cls_e         rd_cls,
  output logic [CORE_W-1:0] rd_owner,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  page_cls_e         wr_cls,
  input  logic [CORE_W-1:0] wr_owner
);
  page_cls_e         cls_q [DEPTH];
  logic [CORE_W-1:0] own_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        cls_q[e] <= CLS_NONE;
        own_q[e] <= '0;
      end
    end else if (wr_en) begin
      cls_q[wr_idx] <= wr_cls;
      own_q[wr_idx] <= wr_owner;
    end
  end

  assign rd_cls   = cls_q[rd_idx];
  assign rd_owner = own_q[rd_idx];

  // R6: a shared slot is never rewritten
  assert_no_downgrade_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cls_q[wr_idx] != CLS_SHARED);

  // R2: only private or shared codes are ever written
  assert_write_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_cls == CLS_PRIV || wr_cls == CLS_SHARED));
endmodule

// File: rtl/page_shoot_chan.sv
module page_shoot_chan #(
  parameter int CORE_W = 4,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CORE_W-1:0] start_core,
  input  logic [IDX_W-1:0]  start_page,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CORE_W-1:0] out_core,
  output logic [IDX_W-1:0]  out_page,
  output logic              busy
);
  logic              pend_q;
  logic [CORE_W-1:0] core_q;
  logic [IDX_W-1:0]  page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      core_q <= '0;
      page_q <= '0;
    end else if (start) begin
      pend_q <= 1'b1;
      core_q <= start_core;
      page_q <= start_page;
    end else if (pend_q && out_ready) begin
      pend_q <= 1'b0;
    end
  end

  assign out_valid = pend_q;
  assign out_core  = core_q;
  assign out_page  = page_q;
  assign busy      = pend_q;

  // R9: request holds with a steady payload until acknowledged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_core) && $stable(out_page)));

  // R4: a new shootdown never starts over one still pending
  assert_single_shoot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/page_class_ctrl.sv
module page_class_ctrl
  import page_class_pkg::*;
#(
  parameter int CORE_W = 4,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [IDX_W-1:0]  miss_page,
  input  logic [CORE_W-1:0] miss_core,
  input  page_cls_e         rd_cls,
  input  logic [CORE_W-1:0] rd_owner,
  output logic              wr_en,
  output page_cls_e         wr_cls,
  output logic [CORE_W-1:0] wr_owner,
  output logic              shoot_start,
  output logic [CORE_W-1:0] shoot_core,
  input  logic              inv_busy,
  input  logic              evc_busy,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_shared,
  output logic [IDX_W-1:0]  rsp_page,
  output logic [CORE_W-1:0] rsp_core
);
  ctrl_state_e       state_q, state_d;
  logic              shared_q, shared_d;
  logic [IDX_W-1:0]  page_q;
  logic [CORE_W-1:0] core_q;
  logic              accept;

  assign miss_ready = (state_q == ST_IDLE);
  assign accept     = miss_valid && miss_ready;
  assign shoot_core = rd_owner;

  always_comb begin
    state_d     = state_q;
    shared_d    = shared_q;
    wr_en       = 1'b0;
    wr_cls      = CLS_PRIV;
    wr_owner    = miss_core;
    shoot_start = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        unique case (rd_cls)
          CLS_NONE: begin
            wr_en    = 1'b1;
            shared_d = 1'b0;
            state_d  = ST_REPLY;
          end
          CLS_PRIV: begin
            if (rd_owner == miss_core) begin
              shared_d = 1'b0;
              state_d  = ST_REPLY;
            end else begin
              wr_en       = 1'b1;
              wr_cls      = CLS_SHARED;
              wr_owner    = rd_owner;
              shoot_start = 1'b1;
              shared_d    = 1'b1;
              state_d     = ST_SHOOT;
            end
          end
          default: begin
            shared_d = 1'b1;
            state_d  = ST_REPLY;
          end
        endcase
      end
      ST_SHOOT: if (!inv_busy && !evc_busy) state_d = ST_REPLY;
      ST_REPLY: if (rsp_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      shared_q <= 1'b0;
      page_q   <= '0;
      core_q   <= '0;
    end else begin
      state_q  <= state_d;
      shared_q <= shared_d;
      if (accept) begin
        page_q <= miss_page;
        core_q <= miss_core;
      end
    end
  end

  assign rsp_valid  = (state_q == ST_REPLY);
  assign rsp_shared = shared_q;
  assign rsp_page   = page_q;
  assign rsp_core   = core_q;

  // R5: no reply while a shootdown is still outstanding
  assert_reply_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!inv_busy && !evc_busy));

  // R8: reply holds until taken
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_shared) &&
                                   $stable(rsp_page) && $stable(rsp_core)));

  // R4: a shootdown is aimed at the old owner, never at the requester
  assert_shoot_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shoot_start |-> (shoot_core != miss_core && rd_cls == CLS_PRIV));

  // R2: a first touch is answered private on the next cycle
  assert_first_touch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_cls == CLS_NONE) |=> (rsp_valid && !rsp_shared));

  // R7: after a reply is taken the block is idle again
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> miss_ready);
endmodule

// File: rtl/page_class_unit.sv
module page_class_unit
  import page_class_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int NUM_PAGES = 64,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [PAGE_W-1:0] miss_page,
  input  logic [CORE_W-1:0] miss_core,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_shared,
  output logic [PAGE_W-1:0] rsp_page,
  output logic [CORE_W-1:0] rsp_core,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [PAGE_W-1:0] inv_page,
  output logic [CORE_W-1:0] inv_core,
  output logic              evc_valid,
  input  logic              evc_ready,
  output logic [PAGE_W-1:0] evc_page,
  output logic [CORE_W-1:0] evc_core
);
  localparam int NUM_CH = 2;  // 0: TLB invalidate, 1: slice evict

  page_cls_e         rd_cls, wr_cls;
  logic [CORE_W-1:0] rd_owner, wr_owner, shoot_core;
  logic              wr_en, shoot_start;

  logic [NUM_CH-1:0] ch_valid, ch_ready, ch_busy;
  logic [CORE_W-1:0] ch_core [NUM_CH];
  logic [PAGE_W-1:0] ch_page [NUM_CH];

  page_class_table #(.DEPTH(NUM_PAGES), .CORE_W(CORE_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(miss_page), .rd_cls(rd_cls), .rd_owner(rd_owner),
    .wr_en(wr_en), .wr_idx(miss_page), .wr_cls(wr_cls), .wr_owner(wr_owner)
  );

  page_class_ctrl #(.CORE_W(CORE_W), .IDX_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_page(miss_page), .miss_core(miss_core),
    .rd_cls(rd_cls), .rd_owner(rd_owner),
    .wr_en(wr_en), .wr_cls(wr_cls), .wr_owner(wr_owner),
    .shoot_start(shoot_start), .shoot_core(shoot_core),
    .inv_busy(ch_busy[0]), .evc_busy(ch_busy[1]),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_shared(rsp_shared),
    .rsp_page(rsp_page), .rsp_core(rsp_core)
  );

  assign ch_ready[0] = inv_ready;
  assign ch_ready[1] = evc_ready;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    page_shoot_chan #(.CORE_W(CORE_W), .IDX_W(PAGE_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .start(shoot_start), .start_core(shoot_core), .start_page(miss_page),
      .out_valid(ch_valid[c]), .out_ready(ch_ready[c]),
      .out_core(ch_core[c]), .out_page(ch_page[c]),
      .busy(ch_busy[c])
    );
  end

  assign inv_valid = ch_valid[0];
  assign inv_core  = ch_core[0];
  assign inv_page  = ch_page[0];
  assign evc_valid = ch_valid[1];
  assign evc_core  = ch_core[1];
  assign evc_page  = ch_page[1];
endmodule

// File: tb/page_class_unit_bench.sv
module page_class_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCORE = 16;
  localparam int NPAGE = 64;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       miss_valid = 1'b0;
  logic       miss_ready;
  logic [5:0] miss_page = '0;
  logic [3:0] miss_core = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic       rsp_shared;
  logic [5:0] rsp_page;
  logic [3:0] rsp_core;
  logic       inv_valid;
  logic       inv_ready = 1'b0;
  logic [5:0] inv_page;
  logic [3:0] inv_core;
  logic       evc_valid;
  logic       evc_ready = 1'b0;
  logic [5:0] evc_page;
  logic [3:0] evc_core;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // model: 0 unclassified, 1 private, 2 shared
  int ref_cls [NPAGE];
  int ref_own [NPAGE];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_class_unit u_page_class_unit (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_page(miss_page), .miss_core(miss_core),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_shared(rsp_shared),
    .rsp_page(rsp_page), .rsp_core(rsp_core),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_page(inv_page), .inv_core(inv_core),
    .evc_valid(evc_valid), .evc_ready(evc_ready), .evc_page(evc_page), .evc_core(evc_core)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_shared(input int page, input int core);
    if (ref_cls[page] == 2) return 1;
    if (ref_cls[page] == 1 && ref_own[page] != core) return 1;
    return 0;
  endfunction

  function automatic int exp_shoots(input int page, input int core);
    return (ref_cls[page] == 1 && ref_own[page] != core) ? 1 : 0;
  endfunction

  function automatic string case_tag(input int page, input int core);
    if (ref_cls[page] == 0) return "R2";
    if (ref_cls[page] == 2) return "R6";
    if (ref_own[page] == core) return "R3";
    return "R4";
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NPAGE; p++) begin
      ref_cls[p] = 0;
      ref_own[p] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk(miss_ready == 1'b1, "R1 ready after reset", int'(miss_ready), 1);
    chk({rsp_valid, inv_valid, evc_valid} == 3'b000, "R1 outputs idle after reset",
        int'({rsp_valid, inv_valid, evc_valid}), 0);
  endtask

  task automatic do_miss(input int page, input int core, input int il, input int el, input int rl);
    int    e_sh, e_cnt, old_own;
    int    inv_hs, evc_hs, iw, ew, rw;
    bit    rsp_seen, inv_seen, evc_seen, done;
    int    first_sh;
    string tag;
    e_sh = exp_shared(page, core);
    e_cnt = exp_shoots(page, core);
    old_own = ref_own[page];
    tag = case_tag(page, core);
    inv_hs = 0; evc_hs = 0; iw = 0; ew = 0; rw = 0;
    rsp_seen = 0; inv_seen = 0; evc_seen = 0; done = 0; first_sh = 0;

    chk(miss_ready == 1'b1, "R7 idle before miss", int'(miss_ready), 1);
    miss_valid = 1'b1;
    miss_page  = 6'(page);
    miss_core  = 4'(core);
    @(negedge clk);
    miss_valid = 1'b0;

    for (int cyc = 0; cyc < 60 && !done; cyc++) begin
      if (miss_ready) chk(1'b0, "R7 busy back-pressure", 1, 0);
      if (inv_valid) begin
        if (!inv_seen) begin
          chk(int'(inv_core) == old_own, "R4 invalidate core", int'(inv_core), old_own);
          chk(int'(inv_page) == page, "R4 invalidate page", int'(inv_page), page);
          inv_seen = 1;
        end
        if (iw >= il) begin inv_ready = 1'b1; inv_hs++; end
        else begin inv_ready = 1'b0; iw++; end
      end else inv_ready = 1'b0;
      if (evc_valid) begin
        if (!evc_seen) begin
          chk(int'(evc_core) == old_own, "R4 evict core", int'(evc_core), old_own);
          chk(int'(evc_page) == page, "R4 evict page", int'(evc_page), page);
          evc_seen = 1;
        end
        if (ew >= el) begin evc_ready = 1'b1; evc_hs++; end
        else begin evc_ready = 1'b0; ew++; end
      end else evc_ready = 1'b0;
      if (rsp_valid) begin
        if (!rsp_seen) begin
          chk(inv_hs == e_cnt && evc_hs == e_cnt, "R5 reply after both acks",
              inv_hs * 10 + evc_hs, e_cnt * 11);
          chk(int'(rsp_shared) == e_sh, tag, int'(rsp_shared), e_sh);
          chk(int'(rsp_core) == core && int'(rsp_page) == page, "R8 reply target",
              int'(rsp_core) * 100 + int'(rsp_page), core * 100 + page);
          first_sh = int'(rsp_shared);
          rsp_seen = 1;
        end else begin
          chk(int'(rsp_shared) == first_sh && int'(rsp_core) == core && int'(rsp_page) == page,
              "R8 reply held", int'(rsp_shared), first_sh);
        end
        if (rw >= rl) begin rsp_ready = 1'b1; done = 1; end
        else begin rsp_ready = 1'b0; rw++; end
      end
      @(negedge clk);
    end
    rsp_ready = 1'b0;
    inv_ready = 1'b0;
    evc_ready = 1'b0;
    chk(done, "R7 reply delivered", int'(done), 1);
    chk(inv_hs == e_cnt, "R4 invalidate count", inv_hs, e_cnt);
    chk(evc_hs == e_cnt, "R4 evict count", evc_hs, e_cnt);
    chk(rsp_valid == 1'b0 && miss_ready == 1'b1, "R7 idle after reply",
        int'(miss_ready), 1);

    if (ref_cls[page] == 0) begin ref_cls[page] = 1; ref_own[page] = core; end
    else if (ref_cls[page] == 1 && ref_own[page] != core) ref_cls[page] = 2;
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < WATCHDOG_CYCLES) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", wd, WATCHDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    do_reset();

    // R1/R2: first touch after reset, boundary page and core
    do_miss(63, 15, 0, 0, 0);
    do_miss(0, 0, 0, 0, 2);
    // R3: owner repeats
    do_miss(63, 15, 0, 0, 1);
    // R4/R5: promotion with invalidate slower than evict
    do_miss(63, 3, 3, 0, 0);
    // R6: former owner now sees shared
    do_miss(63, 15, 0, 0, 0);
    // R4/R5: evict slower than invalidate
    do_miss(0, 9, 0, 3, 1);
    // R10: neighbour page keeps its private owner
    do_miss(5, 2, 0, 0, 0);
    do_miss(6, 2, 0, 0, 0);
    do_miss(6, 7, 2, 2, 0);
    do_miss(5, 2, 0, 0, 0);
    do_miss(5, 4, 1, 1, 3);

    // R1: a second reset forgets shared pages
    do_reset();
    do_miss(63, 3, 0, 0, 0);
    do_miss(63, 3, 0, 0, 0);

    // random mix on a few pages and cores
    for (int i = 0; i < 400; i++) begin
      int pg, cr;
      pg = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, NPAGE - 1))
                                       : int'($urandom_range(0, 7));
      cr = ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 3))
                                       : int'($urandom_range(0, NCORE - 1));
      do_miss(pg, cr, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 3)));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule